// File: doc/BRIEF.md
# Memory-Mapped Interrupt Aggregator

This block merges up to 32 interrupt request lines into one request for a processor. Each line is synchronised to the block clock. It is then captured into a status bit, either as a level or as a rising edge, depending on a per-line build-time mask. Software sees eight 32-bit word registers on a plain read/write bus. These registers give it the status set, the enabled subset that is pending, the enable mask, and the index of the lowest-numbered pending line. They also let it acknowledge lines, set or clear enable bits without a read-modify-write, and control a two-bit master enable.

Master-enable bit 0 allows the processor request. Master-enable bit 1 hands status capture to hardware. While bit 1 is clear, the input lines have no effect, and software may load the status register directly to raise test interrupts. Once bit 1 is set, direct status writes are dropped. The bus has no handshake. A write takes effect on the clock edge where `bus_wr` is high, and read data is a combinational function of `bus_addr` and the current register state.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, status, enable and master enable read zero, pending reads zero, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: Pending (byte address 4) always equals status AND enable.
- R3: The vector (byte address 24) holds the index of the lowest set pending bit, or 0xFFFFFFFF when no pending bit is set.
- R4: `irq_out` is high exactly when master-enable bit 0 (byte address 28) is 1 and at least one pending bit is 1.
- R5: While master-enable bit 1 is 0, the input lines never set any status bit.
- R6: A line whose kind-mask bit is 0 (level) sets its status bit three clock edges after its input rises, and re-sets it on every edge while the input stays high, even across an acknowledge.
- R7: A line whose kind-mask bit is 1 (edge) sets its status bit once per rising input, keeps it after the input falls, and is not re-set by an input that stays high.
- R8: A write to byte address 12 clears every status bit where the written data has a 1 and leaves the others unchanged.
- R9: A write to byte address 16 ORs the data into enable. A write to byte address 20 clears the enable bits where the data has a 1. A write to byte address 8 loads enable.
- R10: A write to byte address 0 loads status when master-enable bit 1 is 0, and is ignored when it is 1.
- R11: Writes to pending, vector or an address of 32 or above change nothing. Addresses 12, 16, 20 and any address of 32 or above read zero.
- R12: When an acknowledge and a new capture hit the same line on the same edge, the status bit ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Raw interrupt request lines |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 6 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Combined request to the processor |

## Verification
The bench first drives a level line while hardware capture is off. A status bit that appears there would show the master gate is missing. It then loads status from software with two bits set and walks the enable mask through set, clear and load writes, so a wrong enable alias shows up as a wrong vector index. Each line class is checked separately: a level line held high across an acknowledge, and an edge line held high across an acknowledge, must give opposite status results. An acknowledge timed to land on the same edge as a fresh capture tells set-wins from clear-wins. A request on line 31 alone checks the top end of the priority encoder.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_COUNT = 8;
  localparam int DATA_W    = 32;

  typedef enum logic [2:0] {
    RG_STATUS = 3'd0,
    RG_PEND   = 3'd1,
    RG_ENABLE = 3'd2,
    RG_ACK    = 3'd3,
    RG_SETEN  = 3'd4,
    RG_CLREN  = 3'd5,
    RG_VECT   = 3'd6,
    RG_MASTER = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int               N    = 32,
  parameter logic [N-1:0]     KIND = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_s,
  input  logic         cap_en,
  input  logic [N-1:0] ack_mask,
  input  logic         sw_load,
  input  logic [N-1:0] sw_data,
  output logic [N-1:0] status
);
  logic [N-1:0] hit;
  logic [N-1:0] status_d;

  for (genvar i = 0; i < N; i++) begin : g_line
    if (KIND[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= line_s[i];
      end
      assign hit[i] = line_s[i] & ~prev_q;
    end else begin : g_level
      assign hit[i] = line_s[i];
    end
  end

  always_comb begin
    if (sw_load) status_d = sw_data;
    else         status_d = (status & ~ack_mask) | (hit & {N{cap_en}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  // R12
  capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (($past(hit) & ~status) == '0));

  // R5
  gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !sw_load) |=> ((status & ~$past(status)) == '0));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_load && (|ack_mask)) |=>
      ((status & $past(ack_mask & ~(hit & {N{cap_en}}))) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign found = |req;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqc_pkg::*;
#(
  parameter int                N_IRQ  = 32,
  parameter logic [N_IRQ-1:0]  KIND   = '0,
  parameter int                ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_lines,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int IDX_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic [WORD_W-1:0] word;
  logic              in_map;
  reg_sel_e          sel;
  logic              wr_hit;
  logic [N_IRQ-1:0]  line_s;
  logic [N_IRQ-1:0]  status;
  logic [N_IRQ-1:0]  enable_q;
  logic [1:0]        master_q;
  logic [N_IRQ-1:0]  pending;
  logic [N_IRQ-1:0]  ack_mask;
  logic              sw_load;
  logic              found;
  logic [IDX_W-1:0]  vec_idx;
  logic [31:0]       vector;
  logic [1:0]        unused_addr_lsb;

  assign unused_addr_lsb = bus_addr[1:0];
  assign word   = bus_addr[ADDR_W-1:2];
  assign in_map = (32'(word) < REG_COUNT);
  assign sel    = reg_sel_e'(word[2:0]);
  assign wr_hit = bus_wr && in_map;

  assign ack_mask = (wr_hit && sel == RG_ACK) ? bus_wdata[N_IRQ-1:0] : '0;
  assign sw_load  = wr_hit && sel == RG_STATUS && !master_q[1];

  irqc_sync #(.W(N_IRQ)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_lines),
    .q     (line_s)
  );

  irqc_capture #(.N(N_IRQ), .KIND(KIND)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_s   (line_s),
    .cap_en   (master_q[1]),
    .ack_mask (ack_mask),
    .sw_load  (sw_load),
    .sw_data  (bus_wdata[N_IRQ-1:0]),
    .status   (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      master_q <= '0;
    end else if (wr_hit) begin
      case (sel)
        RG_ENABLE: enable_q <= bus_wdata[N_IRQ-1:0];
        RG_SETEN:  enable_q <= enable_q | bus_wdata[N_IRQ-1:0];
        RG_CLREN:  enable_q <= enable_q & ~bus_wdata[N_IRQ-1:0];
        RG_MASTER: master_q <= bus_wdata[1:0];
        default:   ;
      endcase
    end
  end

  assign pending = status & enable_q;

  irqc_prio #(.N(N_IRQ)) u_prio (
    .req   (pending),
    .found (found),
    .idx   (vec_idx)
  );

  assign vector  = found ? 32'(vec_idx) : '1;
  assign irq_out = master_q[0] & found;

  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      case (sel)
        RG_STATUS: bus_rdata = 32'(status);
        RG_PEND:   bus_rdata = 32'(pending);
        RG_ENABLE: bus_rdata = 32'(enable_q);
        RG_VECT:   bus_rdata = vector;
        RG_MASTER: bus_rdata = 32'(master_q);
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R9
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sel == RG_SETEN) |=>
      ((enable_q & $past(bus_wdata[N_IRQ-1:0])) == $past(bus_wdata[N_IRQ-1:0])));

  // R9
  clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sel == RG_CLREN) |=>
      ((enable_q & $past(bus_wdata[N_IRQ-1:0])) == '0));

  // R10
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> (status == $past(bus_wdata[N_IRQ-1:0])));

  // R3
  lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pending[vec_idx] &&
      ((pending & ((N_IRQ'(1) << vec_idx) - N_IRQ'(1))) == '0)));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam logic [31:0] KIND_MASK = 32'h0000_00F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #5 clk = ~clk;

  irq_aggregator #(.N_IRQ(32), .KIND(KIND_MASK), .ADDR_W(6)) i_irq_aggregator (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  // monitor: compares 2 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'd0, irq_out} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic rd_exp(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_wr   = 1'b0;
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic irq_exp(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic set_lines(input logic [31:0] v);
    @(negedge clk);
    irq_lines = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_exp(6'd0,  32'h0, "R1 status");
    rd_exp(6'd8,  32'h0, "R1 enable");
    rd_exp(6'd28, 32'h0, "R1 master");
    rd_exp(6'd4,  32'h0, "R1 pending");
    rd_exp(6'd24, 32'hFFFF_FFFF, "R1 vector");
    irq_exp(1'b0, "R1 irq_out");

    // R5 level line with capture off
    set_lines(32'h0000_0002);
    wait_cyc(4);
    rd_exp(6'd0, 32'h0, "R5 no capture while gated");

    // R10 software load, R9 enable aliases, R2/R3/R4
    wr(6'd0, 32'h0000_0A00);
    rd_exp(6'd0, 32'h0000_0A00, "R10 software load");
    wr(6'd16, 32'h0000_0800);
    rd_exp(6'd8, 32'h0000_0800, "R9 set-enable");
    rd_exp(6'd4, 32'h0000_0800, "R2 pending");
    rd_exp(6'd24, 32'd11, "R3 vector 11");
    irq_exp(1'b0, "R4 out low with bit0 clear");
    wr(6'd28, 32'h1);
    irq_exp(1'b1, "R4 out high");
    wr(6'd16, 32'h0000_0200);
    rd_exp(6'd8, 32'h0000_0A00, "R9 set-enable OR");
    rd_exp(6'd24, 32'd9, "R3 vector 9");
    wr(6'd20, 32'h0000_0200);
    rd_exp(6'd8, 32'h0000_0800, "R9 clear-enable");
    rd_exp(6'd24, 32'd11, "R3 vector back to 11");

    // R11 read-only, write-only, unused
    wr(6'd4, 32'hFFFF_FFFF);
    rd_exp(6'd4, 32'h0000_0800, "R11 pending write dropped");
    wr(6'd24, 32'h0);
    rd_exp(6'd24, 32'd11, "R11 vector write dropped");
    rd_exp(6'd12, 32'h0, "R11 ack reads zero");
    rd_exp(6'd16, 32'h0, "R11 set reads zero");
    rd_exp(6'd20, 32'h0, "R11 clear reads zero");
    wr(6'd32, 32'hFFFF_FFFF);
    rd_exp(6'd32, 32'h0, "R11 unused reads zero");
    rd_exp(6'd8, 32'h0000_0800, "R11 unused write no effect");
    rd_exp(6'd28, 32'h1, "R11 unused write master");

    // R8 acknowledge
    wr(6'd12, 32'h0000_0800);
    rd_exp(6'd0, 32'h0000_0200, "R8 ack clears one");
    irq_exp(1'b0, "R4 out low nothing pending");
    rd_exp(6'd24, 32'hFFFF_FFFF, "R3 vector empty");
    wr(6'd12, 32'h0000_0200);
    rd_exp(6'd0, 32'h0, "R8 ack clears other");

    // hardware capture on; line 1 (level) already high
    wr(6'd28, 32'h3);
    wr(6'd0, 32'h0000_0001);
    rd_exp(6'd0, 32'h0000_0002, "R10 write ignored, R6 level capture");
    wr(6'd12, 32'h0000_0002);
    rd_exp(6'd0, 32'h0000_0002, "R6 level re-set after ack");
    set_lines(32'h0);
    wait_cyc(3);
    wr(6'd12, 32'h0000_0002);
    rd_exp(6'd0, 32'h0, "R6 level cleared after drop");

    // R7 edge line 5
    set_lines(32'h0000_0020);
    wait_cyc(2);
    rd_exp(6'd0, 32'h0000_0020, "R7 edge captured");
    wr(6'd8, 32'h0000_0020);
    irq_exp(1'b1, "R4 edge out high");
    rd_exp(6'd24, 32'd5, "R3 vector 5");
    wr(6'd12, 32'h0000_0020);
    wait_cyc(2);
    rd_exp(6'd0, 32'h0, "R7 no re-set while held");
    set_lines(32'h0);
    wait_cyc(3);
    rd_exp(6'd0, 32'h0, "R7 stays clear after fall");

    // R12 ack and edge on same edge (line 6)
    set_lines(32'h0000_0040);
    wait_cyc(1);
    wr(6'd12, 32'h0000_0040);
    rd_exp(6'd0, 32'h0000_0040, "R12 capture wins");

    // mixed level line 3 and edge line 4
    set_lines(32'h0000_0058);
    wait_cyc(2);
    wr(6'd8, 32'hFFFF_FFFF);
    rd_exp(6'd4, 32'h0000_0058, "R2 mixed pending");
    rd_exp(6'd24, 32'd3, "R3 vector 3");
    wr(6'd28, 32'h2);
    irq_exp(1'b0, "R4 out low when bit0 clear");

    // line 31 alone
    set_lines(32'h8000_0000);
    wait_cyc(3);
    wr(6'd12, 32'h7FFF_FFFF);
    rd_exp(6'd4, 32'h8000_0000, "R6 level line 31");
    rd_exp(6'd24, 32'd31, "R3 vector 31");

    wait_cyc(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule